// File: doc/BRIEF.md
# Bus-Reset Synchronized Configuration and Resource Register Block

This block keeps the registers that a serial-bus link publishes to other nodes: the configuration ROM header word, the bus options word and the address of the ROM image in host memory. It also holds the bandwidth-available and channels-available registers that the isochronous resource manager serves. Software can prepare a new ROM image and point the block at it at any moment. The switch to the new image takes place only at the next bus reset, and it changes the header, the options and the address in one step. As a result, other nodes never see a mix of old and new contents.

Each bus reset also returns the resource registers to software-programmable initial values. While the bus-reset event flag is still set, writes to the link's control register and to its four request-filter registers are dropped. This protects them from decisions that software made about a bus topology that no longer exists. A register port handles accesses. Reads complete after a fixed latency, and any read still in flight when a bus reset arrives is dropped without a reply. The header and options fetched from the new image are presented on input pins.

Top module: `cfgrom_sync_csr`

## Requirements
- R1: After reset, the header, options, active ROM address and the five guarded registers read 0. Bandwidth available and its initial register read 0x1333. The channel registers and their initial registers read 0xFFFF_FFFF. Word addresses: 0 header, 1 options, 2 ROM address, 3 bandwidth, 4 channels hi, 5 channels lo, 6 bandwidth initial, 7 channels hi initial, 8 channels lo initial, 9 control, 10 to 13 the filter registers. Addresses 14 and 15 read 0.
- R2: A write to address 2 leaves the value read from address 2 unchanged until a bus reset applies it.
- R3: A write to address 2 arms the update only when link_en and image_ok are both 1. Otherwise the write is dropped, and a later bus reset changes nothing in the ROM registers.
- R4: A bus reset with the update armed loads the header from fetched_hdr and the options from fetched_opts, makes the written address active, and disarms. A later bus reset with no new write reloads nothing.
- R5: Every qualifying write to address 2 arms the update, including a write of the address that is already active.
- R6: Every bus reset loads bandwidth available (13 bits) and channels hi/lo from their initial registers. Software may write both the live registers and the initial registers.
- R7: Writes to addresses 9 to 13 are dropped while reset_evt is 1 and are taken while it is 0.
- R8: Writes to the header and options are taken only while link_en is 0.
- R9: A read issued at address A returns rd_valid=1 with the data of A two clocks later. A read issued in a bus-reset cycle, or still in flight at one, gives no rd_valid.
- R10: When a bus reset and a write fall on the same clock, the reset applies the address armed earlier, and a qualifying address write in that cycle arms the following reset. A write to a live resource register in that cycle loses to the reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | One-cycle pulse marking a bus reset |
| reset_evt | input | 1 | Bus-reset event flag, still pending |
| link_en | input | 1 | Link enabled |
| image_ok | input | 1 | Software marks the new ROM image complete |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address |
| wdata | input | 32 | Write data |
| fetched_hdr | input | 32 | Header word fetched from the new image |
| fetched_opts | input | 32 | Options word fetched from the new image |
| rd_valid | output | 1 | Read data valid |
| rdata | output | 32 | Read data |

## Verification
The sharpest collision puts a bus reset on the same clock as a write to the ROM address register. The bench drives both in one cycle, with an earlier address already armed. It then expects the earlier address to become active, and the newly written one only after a second reset. A second collision puts a bus reset next to a read that is still in the pipeline. The bench judges it by the absence of rd_valid. In both cases the bench also compares every output against its own behavioural model on every clock.

// File: rtl/csr_sync_pkg.sv
package csr_sync_pkg;
  localparam int ADDR_W = 4;
  localparam int DW     = 32;
  localparam logic [ADDR_W-1:0] A_HDR       = 4'd0;
  localparam logic [ADDR_W-1:0] A_OPTS      = 4'd1;
  localparam logic [ADDR_W-1:0] A_MAP       = 4'd2;
  localparam logic [ADDR_W-1:0] A_BW        = 4'd3;
  localparam logic [ADDR_W-1:0] A_CHHI      = 4'd4;
  localparam logic [ADDR_W-1:0] A_CHLO      = 4'd5;
  localparam logic [ADDR_W-1:0] A_BW_INIT   = 4'd6;
  localparam logic [ADDR_W-1:0] A_CHHI_INIT = 4'd7;
  localparam logic [ADDR_W-1:0] A_CHLO_INIT = 4'd8;
  localparam int GUARD_BASE = 9;
  localparam int N_GUARD    = 5;
endpackage

// File: rtl/rom_shadow.sv
module rom_shadow
  import csr_sync_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset,
  input  logic              link_en,
  input  logic              image_ok,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     fetched_hdr,
  input  logic [DW-1:0]     fetched_opts,
  output logic [DW-1:0]     hdr_q,
  output logic [DW-1:0]     opts_q,
  output logic [DW-1:0]     map_q,
  output logic              armed_q
);
  logic [DW-1:0] shadow_q;
  logic          map_wr;
  logic          apply;

  assign map_wr = wr_en && (addr == A_MAP) && link_en && image_ok;
  assign apply  = bus_reset && armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_q    <= '0;
      opts_q   <= '0;
      map_q    <= '0;
      shadow_q <= '0;
      armed_q  <= 1'b0;
    end else begin
      if (apply) begin
        hdr_q  <= fetched_hdr;
        opts_q <= fetched_opts;
        map_q  <= shadow_q;
      end else if (wr_en && !link_en) begin
        if (addr == A_HDR)  hdr_q  <= wdata;
        if (addr == A_OPTS) opts_q <= wdata;
      end
      if (map_wr) begin
        shadow_q <= wdata;
        armed_q  <= 1'b1;
      end else if (bus_reset) begin
        armed_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irm_regs.sv
module irm_regs
  import csr_sync_pkg::*;
#(
  parameter int             BW_W       = 13,
  parameter logic [BW_W-1:0] BW_DEFAULT = 13'h1333,
  parameter logic [DW-1:0]   CH_DEFAULT = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [BW_W-1:0]   bw_q,
  output logic [DW-1:0]     chhi_q,
  output logic [DW-1:0]     chlo_q,
  output logic [BW_W-1:0]   bw_init_q,
  output logic [DW-1:0]     chhi_init_q,
  output logic [DW-1:0]     chlo_init_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bw_q        <= BW_DEFAULT;
      chhi_q      <= CH_DEFAULT;
      chlo_q      <= CH_DEFAULT;
      bw_init_q   <= BW_DEFAULT;
      chhi_init_q <= CH_DEFAULT;
      chlo_init_q <= CH_DEFAULT;
    end else begin
      if (wr_en && addr == A_BW_INIT)   bw_init_q   <= wdata[BW_W-1:0];
      if (wr_en && addr == A_CHHI_INIT) chhi_init_q <= wdata;
      if (wr_en && addr == A_CHLO_INIT) chlo_init_q <= wdata;
      if (bus_reset) begin
        bw_q   <= bw_init_q;
        chhi_q <= chhi_init_q;
        chlo_q <= chlo_init_q;
      end else if (wr_en) begin
        if (addr == A_BW)   bw_q   <= wdata[BW_W-1:0];
        if (addr == A_CHHI) chhi_q <= wdata;
        if (addr == A_CHLO) chlo_q <= wdata;
      end
    end
  end
endmodule

// File: rtl/guard_regs.sv
module guard_regs
  import csr_sync_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reset_evt,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DW-1:0]              wdata,
  output logic [N_GUARD-1:0][DW-1:0] guard_q
);
  for (genvar i = 0; i < N_GUARD; i++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(GUARD_BASE + i);
    always_ff @(posedge clk) begin
      if (rst)
        guard_q[i] <= '0;
      else if (wr_en && !reset_evt && addr == MY_ADDR)
        guard_q[i] <= wdata;
    end
  end
endmodule

// File: rtl/read_pipe.sv
module read_pipe
  import csr_sync_pkg::*;
#(
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_reset,
  input  logic          rd_en,
  input  logic [DW-1:0] rd_word,
  output logic          rd_valid,
  output logic [DW-1:0] rdata
);
  logic [RD_LAT-1:0]         vld_q;
  logic [RD_LAT-1:0][DW-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (rst || bus_reset) vld_q[0] <= 1'b0;
    else                  vld_q[0] <= rd_en;
    dat_q[0] <= rd_word;
  end

  for (genvar s = 1; s < RD_LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst || bus_reset) vld_q[s] <= 1'b0;
      else                  vld_q[s] <= vld_q[s-1];
      dat_q[s] <= dat_q[s-1];
    end
  end

  assign rd_valid = vld_q[RD_LAT-1];
  assign rdata    = dat_q[RD_LAT-1];
endmodule

// File: rtl/cfgrom_sync_csr.sv
module cfgrom_sync_csr
  import csr_sync_pkg::*;
#(
  parameter int              RD_LAT     = 2,
  parameter int              BW_W       = 13,
  parameter logic [BW_W-1:0] BW_DEFAULT = 13'h1333,
  parameter logic [DW-1:0]   CH_DEFAULT = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_reset,
  input  logic        reset_evt,
  input  logic        link_en,
  input  logic        image_ok,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  input  logic [31:0] fetched_hdr,
  input  logic [31:0] fetched_opts,
  output logic        rd_valid,
  output logic [31:0] rdata
);
  logic [DW-1:0]              hdr_q, opts_q, map_q;
  logic                       armed_q;
  logic [BW_W-1:0]            bw_q, bw_init_q;
  logic [DW-1:0]              chhi_q, chlo_q, chhi_init_q, chlo_init_q;
  logic [N_GUARD-1:0][DW-1:0] guard_q;
  logic [DW-1:0]              rd_word;

  rom_shadow u_rom (
    .clk, .rst, .bus_reset, .link_en, .image_ok, .wr_en, .addr, .wdata,
    .fetched_hdr, .fetched_opts,
    .hdr_q, .opts_q, .map_q, .armed_q
  );

  irm_regs #(.BW_W(BW_W), .BW_DEFAULT(BW_DEFAULT), .CH_DEFAULT(CH_DEFAULT)) u_irm (
    .clk, .rst, .bus_reset, .wr_en, .addr, .wdata,
    .bw_q, .chhi_q, .chlo_q, .bw_init_q, .chhi_init_q, .chlo_init_q
  );

  guard_regs u_guard (
    .clk, .rst, .reset_evt, .wr_en, .addr, .wdata, .guard_q
  );

  always_comb begin
    rd_word = '0;
    case (addr)
      A_HDR:       rd_word = hdr_q;
      A_OPTS:      rd_word = opts_q;
      A_MAP:       rd_word = map_q;
      A_BW:        rd_word = {{(DW-BW_W){1'b0}}, bw_q};
      A_CHHI:      rd_word = chhi_q;
      A_CHLO:      rd_word = chlo_q;
      A_BW_INIT:   rd_word = {{(DW-BW_W){1'b0}}, bw_init_q};
      A_CHHI_INIT: rd_word = chhi_init_q;
      A_CHLO_INIT: rd_word = chlo_init_q;
      default: begin
        for (int g = 0; g < N_GUARD; g++)
          if (addr == ADDR_W'(GUARD_BASE + g)) rd_word = guard_q[g];
      end
    endcase
  end

  read_pipe #(.RD_LAT(RD_LAT)) u_rd (
    .clk, .rst, .bus_reset, .rd_en, .rd_word, .rd_valid, .rdata
  );
endmodule

// File: rtl/cfgrom_sync_csr_chk.sv
module cfgrom_sync_csr_chk
  import csr_sync_pkg::*;
#(
  parameter int BW_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_reset,
  input logic              reset_evt,
  input logic              link_en,
  input logic              image_ok,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_valid,
  input logic              armed,
  input logic [DW-1:0]     map_active,
  input logic [BW_W-1:0]   bw_avail,
  input logic [BW_W-1:0]   bw_init,
  input logic [DW-1:0]     ctrl_reg
);
  logic map_req;
  assign map_req = wr_en && (addr == A_MAP) && link_en && image_ok;

  AST_FLUSH_ON_RESET: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> !rd_valid); // R9
  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_reset |=> $stable(map_active)); // R2
  AST_ARM_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    map_req |=> armed); // R5
  AST_NO_ARM_UNQUALIFIED: assert property (@(posedge clk) disable iff (rst)
    (!armed && !map_req) |=> !armed); // R3
  AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_reset && !map_req) |=> !armed); // R4
  AST_BW_RELOAD: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (bw_avail == $past(bw_init))); // R6
  AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (rst)
    reset_evt |=> $stable(ctrl_reg)); // R7
endmodule

bind cfgrom_sync_csr cfgrom_sync_csr_chk #(.BW_W(BW_W)) u_chk (
  .clk(clk), .rst(rst), .bus_reset(bus_reset), .reset_evt(reset_evt),
  .link_en(link_en), .image_ok(image_ok), .wr_en(wr_en), .addr(addr),
  .rd_valid(rd_valid), .armed(armed_q), .map_active(map_q),
  .bw_avail(bw_q), .bw_init(bw_init_q), .ctrl_reg(guard_q[0])
);

// File: tb/cfgrom_sync_csr_bench.sv
module cfgrom_sync_csr_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_reset = 0, reset_evt = 0, link_en = 0, image_ok = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, fetched_hdr = '0, fetched_opts = '0;
  logic        rd_valid;
  logic [31:0] rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  cfgrom_sync_csr u_cfgrom_sync_csr (
    .clk, .rst, .bus_reset, .reset_evt, .link_en, .image_ok, .wr_en, .rd_en,
    .addr, .wdata, .fetched_hdr, .fetched_opts, .rd_valid, .rdata
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m [0:15];
  logic [31:0] m_shadow;
  bit          m_armed;
  logic [31:0] q_data [$];
  bit          q_vld  [$];

  function automatic logic [31:0] mread(logic [3:0] a);
    return (a <= 4'd13) ? m[a] : 32'h0;
  endfunction

  task automatic model_init();
    foreach (m[i]) m[i] = 32'h0;
    m[3] = 32'h1333; m[6] = 32'h1333;
    m[4] = 32'hFFFF_FFFF; m[5] = 32'hFFFF_FFFF;
    m[7] = 32'hFFFF_FFFF; m[8] = 32'hFFFF_FFFF;
    m_shadow = 0; m_armed = 0;
    q_data = {}; q_vld = {};
    q_vld.push_back(0); q_data.push_back(0);
    q_vld.push_back(0); q_data.push_back(0);
  endtask

  always @(posedge clk) begin
    if (rst) model_init();
    else begin
      logic [31:0] o [0:15];
      bit was_armed;
      o = m;
      was_armed = m_armed;
      void'(q_vld.pop_back()); void'(q_data.pop_back());
      q_vld.push_front(rd_en); q_data.push_front(mread(addr));
      if (bus_reset) foreach (q_vld[i]) q_vld[i] = 0;
      if (bus_reset) begin
        m[3] = o[6]; m[4] = o[7]; m[5] = o[8];
        if (was_armed) begin
          m[0] = fetched_hdr; m[1] = fetched_opts; m[2] = m_shadow;
        end
      end
      if (wr_en) begin
        if ((addr == 0 || addr == 1) && !link_en && !(bus_reset && was_armed)) m[addr] = wdata;
        if (addr == 2 && link_en && image_ok) begin m_shadow = wdata; m_armed = 1; end
        if (addr >= 3 && addr <= 5 && !bus_reset) m[addr] = (addr == 3) ? {19'h0, wdata[12:0]} : wdata;
        if (addr >= 6 && addr <= 8) m[addr] = (addr == 6) ? {19'h0, wdata[12:0]} : wdata;
        if (addr >= 9 && addr <= 13 && !reset_evt) m[addr] = wdata;
      end
      if (bus_reset && !(wr_en && addr == 2 && link_en && image_ok)) m_armed = 0;
    end
  end

  // every-clock comparison against the model (R9 timing and data)
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (rd_valid !== q_vld[1] || (q_vld[1] && rdata !== q_data[1])) begin
        fails++;
        $display("FAIL R9 model compare: valid=%0b data=%h expected valid=%0b data=%h",
                 rd_valid, rdata, q_vld[1], q_data[1]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic bres();
    @(negedge clk); bus_reset = 1;
    @(negedge clk); bus_reset = 0;
  endtask

  task automatic rd_expect(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    @(negedge clk);
    checks++;
    if (rd_valid !== 1'b1 || rdata !== exp) begin
      fails++;
      $display("FAIL %s addr %0d: valid=%0b data=%h expected valid=1 data=%h", tag, a, rd_valid, rdata, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd_expect(0, 32'h0, "R1 header");
    rd_expect(2, 32'h0, "R1 map");
    rd_expect(3, 32'h1333, "R1 bandwidth");
    rd_expect(4, 32'hFFFF_FFFF, "R1 chan hi");
    rd_expect(8, 32'hFFFF_FFFF, "R1 chan lo init");
    rd_expect(9, 32'h0, "R1 control");
    rd_expect(15, 32'h0, "R1 unmapped");
    // R8 header/options writes gated by link_en
    wr(0, 32'hA1);
    rd_expect(0, 32'hA1, "R8 header write link off");
    link_en = 1;
    wr(0, 32'hB2);
    wr(1, 32'hC3);
    rd_expect(0, 32'hA1, "R8 header write ignored");
    rd_expect(1, 32'h0, "R8 options write ignored");
    // R3 unqualified map write
    fetched_hdr = 32'h1111_0000; fetched_opts = 32'h2222_0000;
    wr(2, 32'h1000);
    bres();
    rd_expect(2, 32'h0, "R3 map not armed");
    rd_expect(0, 32'hA1, "R3 header not reloaded");
    // R2 / R4 qualified update
    image_ok = 1;
    wr(2, 32'h2000);
    rd_expect(2, 32'h0, "R2 map old value");
    bres();
    rd_expect(2, 32'h2000, "R4 map applied");
    rd_expect(0, 32'h1111_0000, "R4 header reloaded");
    rd_expect(1, 32'h2222_0000, "R4 options reloaded");
    fetched_hdr = 32'h3333_0000;
    bres();
    rd_expect(0, 32'h1111_0000, "R4 disarmed no reload");
    // R5 same-value write still arms
    fetched_hdr = 32'h4444_0000;
    wr(2, 32'h2000);
    bres();
    rd_expect(0, 32'h4444_0000, "R5 same value arms");
    // R6 resource reload
    wr(3, 32'h5);
    rd_expect(3, 32'h5, "R6 bandwidth write");
    wr(6, 32'h0777);
    wr(7, 32'h0000_FFFF);
    wr(5, 32'h1234_5678);
    rd_expect(3, 32'h5, "R6 live unchanged before reset");
    bres();
    rd_expect(3, 32'h777, "R6 bandwidth reload");
    rd_expect(4, 32'h0000_FFFF, "R6 chan hi reload");
    rd_expect(5, 32'hFFFF_FFFF, "R6 chan lo reload");
    // R7 guarded registers
    reset_evt = 1;
    wr(9, 32'h55);
    wr(11, 32'h66);
    rd_expect(9, 32'h0, "R7 control guarded");
    rd_expect(11, 32'h0, "R7 filter guarded");
    reset_evt = 0;
    wr(12, 32'h77);
    rd_expect(12, 32'h77, "R7 filter taken");
    // R9 read in flight dropped by bus reset
    @(negedge clk); rd_en = 1; addr = 0;
    @(negedge clk); rd_en = 0; bus_reset = 1;
    @(negedge clk); bus_reset = 0;
    checks++;
    if (rd_valid !== 1'b0) begin
      fails++; $display("FAIL R9 in-flight read: valid=%0b expected 0", rd_valid);
    end
    @(negedge clk); rd_en = 1; bus_reset = 1;
    @(negedge clk); rd_en = 0; bus_reset = 0;
    @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0) begin
      fails++; $display("FAIL R9 read in reset cycle: valid=%0b expected 0", rd_valid);
    end
    // R10 same-cycle collisions
    wr(2, 32'h3000);
    fetched_hdr = 32'h5555_0000;
    @(negedge clk); bus_reset = 1; wr_en = 1; addr = 2; wdata = 32'h4000;
    @(negedge clk); bus_reset = 0; wr_en = 0;
    rd_expect(2, 32'h3000, "R10 earlier address applied");
    bres();
    rd_expect(2, 32'h4000, "R10 same-cycle write armed next");
    @(negedge clk); bus_reset = 1; wr_en = 1; addr = 3; wdata = 32'h9;
    @(negedge clk); bus_reset = 0; wr_en = 0;
    rd_expect(3, 32'h777, "R10 reload beats write");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule